// File: doc/BRIEF.md
# Per-Bin Exponential Spectrum Averager

This block smooths a stream of transform results over time, frame by frame. Each incoming value carries the frequency bin it belongs to. The block keeps the last result for every bin in an internal history RAM. When averaging is requested, it forms a weighted mix of the new value and that bin's history, using a programmable fraction `alpha` as the weight. The result is emitted with its bin index and is also written back as the new history for that bin.

A three-bit output-mode code travels with each sample. Its top bit requests averaging. Two of its encodings are illegal: a sample carrying an illegal code is dropped and a sticky error flag is raised. A weight of zero turns averaging off, and so does a bin that has no history yet, meaning it has not been seen since reset or since the last history clear. In both cases values pass straight through.

The block accepts one sample per clock, and every result appears a fixed three cycles later. Samples are written in order and may repeat the same bin on consecutive cycles.

Top module: `specAvgUnit`

## Requirements
- R1: After reset, `outValid` and `modeErr` are 0, and the weight register is 0. As a result, averaging-mode samples pass through unchanged until a nonzero weight is loaded.
- R2: `modeSel` bit 2 requests averaging, bit 1 selects the complex (XY) output family and bit 0 selects the decibel output format. Codes 3'b011 and 3'b111 are illegal, and the other six codes are legal.
- R3: A sample that has `inValid` high and a legal code produces `outValid` high, with `outBin` equal to its bin, exactly three rising edges after the edge that captures it. One sample can be accepted on every clock.
- R4: For legal codes with bit 2 = 0, `outSample` equals `inSample`, whatever the weight and history.
- R5: With bit 2 = 1, a nonzero weight `a` and history `h` for the bin, the result for a new value `x` is `h + ((a*(x-h) + 2^14) >>> 15)`. Here `a` is 15-bit unsigned (fraction a/32768), the values are 16-bit two's complement, and `>>>` is an arithmetic shift.
- R6: When the weight register is 0, averaging-mode samples pass through unchanged.
- R7: The first sample for a bin after reset or after `histClr` passes through unchanged and seeds that bin's history.
- R8: Every emitted result becomes the history for its bin, in every legal mode, and this includes the case where the same bin arrives on back-to-back cycles.
- R9: A sample that has `inValid` high and an illegal code produces no output and leaves the history unchanged. It sets `modeErr` one edge later, and `modeErr` then stays high until reset.
- R10: `alphaWe` loads `alphaIn` into the weight register on the next edge. `histClr` forgets all bins on the next edge. Both are used only while no sample is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| alphaWe | input | 1 | Load strobe for the weight register |
| alphaIn | input | ALPHA_W (15) | Weight value, unsigned fraction |
| histClr | input | 1 | Forget the history of all bins |
| modeSel | input | 3 | Output-mode code {avg, xy, db} |
| inValid | input | 1 | Sample strobe |
| inBin | input | BIN_W (10) | Bin index of the sample |
| inSample | input | DATA_W (16) | Sample value, two's complement |
| outValid | output | 1 | Result strobe |
| outBin | output | BIN_W (10) | Bin index of the result |
| outSample | output | DATA_W (16) | Averaged or passed-through value |
| modeErr | output | 1 | Sticky illegal-mode flag |

## Verification
Results are due exactly three rising edges after the capturing edge, and `modeErr` is due one edge after an illegal sample. When the bench drives a sample, it records the cycle count together with the expected bin and value. At each falling edge it compares `outValid` against that recorded due cycle, so an early, late, missing or extra result counts as a miscompare. The reference history is updated in the order the samples are driven, so back-to-back samples for the same bin test the forwarding path one cycle after the earlier write. Weight changes and history clears are made only with the pipeline drained.

// File: rtl/specAvgPkg.sv
package specAvgPkg;

  // Strobes sent from the control path to the datapath each cycle
  typedef struct packed {
    logic capture;   // load stage-1 registers from the input
    logic advance;   // move stage 1 into stage 2
    logic forward;   // stage-1 bin matches in-flight stage-2 bin
    logic blend;     // stage-2 result uses the weighted mix
    logic commit;    // stage-2 result is written and emitted
  } avgStrobes_t;

  function automatic logic modeIsBad(input logic [2:0] m);
    return m[1] & m[0];
  endfunction

  function automatic logic modeWantsAvg(input logic [2:0] m);
    return m[2];
  endfunction

endpackage

// File: rtl/specAvgCtl.sv
module specAvgCtl
  import specAvgPkg::*;
#(
  parameter int BIN_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             histClr,
  input  logic [2:0]       modeSel,
  input  logic             inValid,
  input  logic [BIN_W-1:0] inBin,
  input  logic             alphaZero,
  output avgStrobes_t      strobes,
  output logic             outValid,
  output logic             modeErr
);
  localparam int NBINS = 1 << BIN_W;

  logic             v1, v2, avg1, blend2, histKnown, badMode;
  logic [BIN_W-1:0] bin1, bin2;
  logic [NBINS-1:0] seen;

  always_comb begin
    badMode          = modeIsBad(modeSel);
    strobes.capture  = inValid & ~badMode;
    strobes.advance  = v1;
    strobes.forward  = v1 & v2 & (bin1 == bin2);
    histKnown        = seen[bin1] | strobes.forward;
    strobes.blend    = v2 & blend2 & ~alphaZero;
    strobes.commit   = v2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      avg1     <= 1'b0;
      blend2   <= 1'b0;
      bin1     <= '0;
      bin2     <= '0;
      outValid <= 1'b0;
      modeErr  <= 1'b0;
      seen     <= '0;
    end else begin
      v1 <= strobes.capture;
      if (strobes.capture) begin
        bin1 <= inBin;
        avg1 <= modeWantsAvg(modeSel);
      end
      v2 <= v1;
      if (v1) begin
        bin2   <= bin1;
        blend2 <= avg1 & histKnown;
      end
      outValid <= v2;
      if (inValid && badMode) modeErr <= 1'b1;
      if (histClr) seen <= '0;
      else if (v2) seen[bin2] <= 1'b1;
    end
  end

endmodule

// File: rtl/specAvgDp.sv
module specAvgDp
  import specAvgPkg::*;
#(
  parameter int BIN_W   = 10,
  parameter int DATA_W  = 16,
  parameter int ALPHA_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               alphaWe,
  input  logic [ALPHA_W-1:0] alphaIn,
  input  logic [BIN_W-1:0]   inBin,
  input  logic [DATA_W-1:0]  inSample,
  input  avgStrobes_t        strobes,
  output logic               alphaZero,
  output logic [BIN_W-1:0]   outBin,
  output logic [DATA_W-1:0]  outSample
);
  localparam int NBINS   = 1 << BIN_W;
  localparam int PW      = DATA_W + ALPHA_W + 2;
  localparam int ROUND_I = 1 << (ALPHA_W - 1);

  logic [ALPHA_W-1:0] alphaReg;
  logic [DATA_W-1:0]  histMem [NBINS];

  logic [DATA_W-1:0]        s1Sample, s2New, s2Hist, histRd, blended, result;
  logic [BIN_W-1:0]         s1Bin, s2Bin;
  logic signed [DATA_W:0]   diff;
  logic signed [PW-1:0]     prod, rounded;

  assign alphaZero = (alphaReg == '0);

  // Stage 2: weighted mix, rounded to nearest
  always_comb begin
    diff    = $signed({s2New[DATA_W-1], s2New}) - $signed({s2Hist[DATA_W-1], s2Hist});
    prod    = diff * $signed({1'b0, alphaReg});
    rounded = (prod + $signed(PW'(ROUND_I))) >>> ALPHA_W;
    blended = s2Hist + rounded[DATA_W-1:0];
    result  = strobes.blend ? blended : s2New;
  end

  // Stage 1: history read, bypassing the write still in flight
  always_comb begin
    histRd = strobes.forward ? result : histMem[s1Bin];
  end

  always_ff @(posedge clk) begin
    if (!rstN) alphaReg <= '0;
    else if (alphaWe) alphaReg <= alphaIn;
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      s1Sample <= inSample;
      s1Bin    <= inBin;
    end
    if (strobes.advance) begin
      s2New  <= s1Sample;
      s2Hist <= histRd;
      s2Bin  <= s1Bin;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) histMem[s2Bin] <= result;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSample <= '0;
      outBin    <= '0;
    end else if (strobes.commit) begin
      outSample <= result;
      outBin    <= s2Bin;
    end
  end

endmodule

// File: rtl/specAvgUnit.sv
module specAvgUnit
  import specAvgPkg::*;
#(
  parameter int BIN_W   = 10,
  parameter int DATA_W  = 16,
  parameter int ALPHA_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               alphaWe,
  input  logic [ALPHA_W-1:0] alphaIn,
  input  logic               histClr,
  input  logic [2:0]         modeSel,
  input  logic               inValid,
  input  logic [BIN_W-1:0]   inBin,
  input  logic [DATA_W-1:0]  inSample,
  output logic               outValid,
  output logic [BIN_W-1:0]   outBin,
  output logic [DATA_W-1:0]  outSample,
  output logic               modeErr
);
  avgStrobes_t strobes;
  logic        alphaZero;

  specAvgCtl #(.BIN_W(BIN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .histClr(histClr), .modeSel(modeSel),
    .inValid(inValid), .inBin(inBin), .alphaZero(alphaZero),
    .strobes(strobes), .outValid(outValid), .modeErr(modeErr)
  );

  specAvgDp #(.BIN_W(BIN_W), .DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_dp (
    .clk(clk), .rstN(rstN), .alphaWe(alphaWe), .alphaIn(alphaIn),
    .inBin(inBin), .inSample(inSample), .strobes(strobes),
    .alphaZero(alphaZero), .outBin(outBin), .outSample(outSample)
  );

endmodule

// File: rtl/specAvgChk.sv
module specAvgChk #(
  parameter int BIN_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [2:0]       modeSel,
  input logic [BIN_W-1:0] inBin,
  input logic             outValid,
  input logic [BIN_W-1:0] outBin,
  input logic             modeErr
);
  logic legalIn, badIn;
  assign legalIn = inValid & ~(modeSel[1] & modeSel[0]);
  assign badIn   = inValid &  (modeSel[1] & modeSel[0]);

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rstN)
    legalIn |-> ##3 outValid);                                       // R3
  AST_BIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    legalIn |-> ##3 (outBin == $past(inBin, 3)));                    // R3
  AST_BAD_MODE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    badIn |-> ##3 !outValid);                                        // R9
  AST_BAD_MODE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    badIn |=> modeErr);                                              // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);                                            // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && !modeErr));                              // R1

endmodule

bind specAvgUnit specAvgChk #(.BIN_W(BIN_W)) u_specAvgChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
  .inBin(inBin), .outValid(outValid), .outBin(outBin), .modeErr(modeErr)
);

// File: tb/test_specAvgUnit.sv
module test_specAvgUnit;
  localparam int BW = 4;
  localparam int NB = 1 << BW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          alphaWe = 1'b0;
  logic [14:0]   alphaIn = '0;
  logic          histClr = 1'b0;
  logic [2:0]    modeSel = '0;
  logic          inValid = 1'b0;
  logic [BW-1:0] inBin = '0;
  logic [15:0]   inSample = '0;
  logic          outValid, modeErr;
  logic [BW-1:0] outBin;
  logic [15:0]   outSample;

  specAvgUnit #(.BIN_W(BW)) i_specAvgUnit (
    .clk(clk), .rstN(rstN), .alphaWe(alphaWe), .alphaIn(alphaIn),
    .histClr(histClr), .modeSel(modeSel), .inValid(inValid), .inBin(inBin),
    .inSample(inSample), .outValid(outValid), .outBin(outBin),
    .outSample(outSample), .modeErr(modeErr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nBad = 0;
  bit running = 1'b0;

  // Reference state
  int          refAlpha = 0;
  logic [15:0] refHist [NB];
  bit          refSeen [NB];
  int          qCyc[$];
  logic [BW-1:0] qBin[$];
  logic [15:0] qVal[$];
  string       qTag[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] mixRef(input logic [15:0] h, input logic [15:0] x, input int a);
    longint d, p, r;
    d = longint'($signed(x)) - longint'($signed(h));
    p = d * a;
    r = (p + 16384) >>> 15;
    return 16'(longint'($signed(h)) + r);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Output comparison, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (qCyc.size() > 0 && qCyc[0] == cyc) begin
        check(outValid == 1'b1, {qTag[0], " R3 valid"}, outValid, 1);
        check(outBin == qBin[0], {qTag[0], " R3 bin"}, outBin, qBin[0]);
        check(outSample == qVal[0], qTag[0], $signed(outSample), $signed(qVal[0]));
        void'(qCyc.pop_front()); void'(qBin.pop_front());
        void'(qVal.pop_front()); void'(qTag.pop_front());
      end else if (outValid) begin
        check(1'b0, "R3/R9 unexpected output", 1, 0);
      end
    end
  end

  task automatic send(input logic [BW-1:0] b, input logic [15:0] x, input logic [2:0] m, input string tag);
    logic [15:0] res;
    bit blend;
    @(negedge clk);
    inValid = 1'b1; inBin = b; inSample = x; modeSel = m;
    if (!(m[1] & m[0])) begin
      blend = m[2] && refSeen[b] && (refAlpha != 0);
      res = blend ? mixRef(refHist[b], x, refAlpha) : x;
      refHist[b] = res; refSeen[b] = 1'b1;
      qCyc.push_back(cyc + 3); qBin.push_back(b); qVal.push_back(res); qTag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setAlpha(input int a);
    @(negedge clk); inValid = 1'b0; alphaWe = 1'b1; alphaIn = 15'(a);
    @(negedge clk); alphaWe = 1'b0;
    refAlpha = a;
  endtask

  task automatic clearHist();
    @(negedge clk); inValid = 1'b0; histClr = 1'b1;
    @(negedge clk); histClr = 1'b0;
    for (int i = 0; i < NB; i++) refSeen[i] = 1'b0;
  endtask

  function automatic logic [15:0] nextRnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin refHist[i] = '0; refSeen[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(modeErr == 1'b0, "R1 modeErr after reset", modeErr, 0);
    running = 1'b1;

    // R1: weight resets to zero -> averaging mode passes through on repeat frames
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < NB; b++) send(BW'(b), nextRnd(), 3'b100, "R1 reset weight passthrough");
    idle(4);

    // R4: non-averaging codes ignore weight and history
    setAlpha(16'h4000);
    for (int m = 0; m < 3; m++)
      for (int b = 0; b < NB; b++) send(BW'(b), nextRnd(), 3'(m), "R4 non-averaging passthrough");
    idle(4);

    // R5/R7: sweep weights, fresh history each time, several frames
    foreach (lfsr[k]) begin end
    begin
      int alphas[6] = '{1, 16'h4000, 16'h7FFF, 16'h2AAB, 16'h0100, 16'h6000};
      for (int ai = 0; ai < 6; ai++) begin
        setAlpha(alphas[ai]);
        clearHist();
        for (int b = 0; b < NB; b++) send(BW'(b), nextRnd(), 3'b100, "R7 first frame seeds");
        for (int f = 0; f < 3; f++)
          for (int b = 0; b < NB; b++) send(BW'(b), nextRnd(), 3'(4 + (f % 3)), "R5 blend");
        idle(4);
      end
    end

    // R5 extremes: swing between full-scale values
    setAlpha(16'h7FFF);
    clearHist();
    for (int k = 0; k < 8; k++) begin
      send(4'd2, 16'h8000, 3'b101, "R5 extreme negative");
      send(4'd3, 16'h7FFF, 3'b101, "R5 extreme positive");
      send(4'd2, 16'h7FFF, 3'b101, "R5 extreme swing up");
      send(4'd3, 16'h8000, 3'b101, "R5 extreme swing down");
    end
    idle(4);

    // R8: same bin back to back exercises the bypass
    setAlpha(16'h3000);
    for (int k = 0; k < 12; k++) send(4'd5, nextRnd(), 3'b110, "R8 back-to-back bin");
    for (int k = 0; k < 12; k++) send(BW'(k % 2 + 7), nextRnd(), 3'b100, "R8 alternating bins");
    idle(4);

    // R6: weight zero with seeded history
    setAlpha(0);
    for (int b = 0; b < NB; b++) send(BW'(b), nextRnd(), 3'b100, "R6 zero weight passthrough");
    idle(4);

    // R9: illegal codes dropped, flag set, history untouched
    setAlpha(16'h4000);
    send(4'd9, 16'h1000, 3'b100, "R9 seed");
    idle(4);
    @(negedge clk); inValid = 1'b1; inBin = 4'd9; inSample = 16'h7000; modeSel = 3'b011;
    @(negedge clk); inValid = 1'b0;
    check(modeErr == 1'b1, "R9 modeErr after 011", modeErr, 1);
    @(negedge clk); inValid = 1'b1; inBin = 4'd9; inSample = 16'h7000; modeSel = 3'b111;
    @(negedge clk); inValid = 1'b0;
    idle(4);
    check(modeErr == 1'b1, "R9 modeErr sticky", modeErr, 1);
    send(4'd9, 16'h2000, 3'b100, "R9 history untouched");
    idle(4);

    // R10: history clear makes next averaged sample pass through
    clearHist();
    send(4'd9, 16'h0123, 3'b100, "R10 clear then passthrough");
    send(4'd9, 16'h4567, 3'b100, "R10 blend after reseed");
    idle(4);

    // Mixed stream, illegal codes interleaved
    setAlpha(16'h5555);
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] r;
      r = nextRnd();
      send(BW'(r[3:0]), nextRnd(), r[6:4], "R2 mixed stream");
    end
    idle(6);
    check(modeErr == 1'b1, "R2 modeErr after mixed stream", modeErr, 1);
    check(qCyc.size() == 0, "R3 all results delivered", qCyc.size(), 0);

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule